// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a NOR flash controller. Each write cycle from the host reaches it as a one-clock strobe with an address and a data word. The decoder follows the multi-cycle, unlock-prefixed command protocol and reduces each accepted sequence to a single operation pulse. Every pulse carries the address and data of the write that completed the sequence. Executing the operation, and the memory array itself, belong to downstream logic.

The decoder has three modes. In normal mode every command needs the two-write unlock prefix. Bypass mode is entered by command and accepts a program as just a set-up write followed by an address/data write; a two-write exit sequence leaves it. Autoselect mode is entered by command and left only by a reset write. In normal mode, a write that does not fit the sequence in progress drops the partial sequence, and the decoder waits for a fresh start.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, op_valid, bypass_active and autosel_active are 0 and op_code is 0.
- R2: In normal mode, the four writes AA@555, 55@2AA, A0@555, then any address/data produce op_code 1 (program). op_addr and op_data take the full-width address and data of the fourth write.
- R3: The six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then data 30 at any address produce op_code 2 (sector erase), with op_addr equal to that last address.
- R4: The same six-write prefix ending in data 10 at address 555 produces op_code 3 (chip erase). Data 10 at any other address aborts the sequence without a pulse.
- R5: AA@555, 55@2AA, 90@555 produce op_code 4 and set autosel_active. While it is set, only a write of data F0 has an effect: it produces op_code 9 and clears the flag. All other writes produce no pulse.
- R6: AA@555, 55@2AA, 20@555 produce op_code 5 and set bypass_active.
- R7: In bypass mode, data A0 at any address followed by any write produces op_code 1, carrying the second write's address and data. The decoder stays in bypass mode.
- R8: In bypass mode, data 90 followed by data 00 (any addresses) produces op_code 6 and clears bypass_active. A second write other than 00 produces no pulse and leaves bypass mode active.
- R9: In normal mode, a write whose address or data does not match the next expected cycle produces no pulse and drops the partial sequence, so a complete sequence must start again from the first unlock write.
- R10: In normal mode, data F0 at any address produces op_code 9 and drops any partial sequence. The exception is the program data write, where F0 is taken as program data.
- R11: A single write of data B0 produces op_code 7 (erase suspend), and a single write of data 30 produces op_code 8 (erase resume). Both apply at any address, only with no sequence in progress, in normal or bypass mode.
- R12: Addresses 555 and 2AA are compared on address bits [10:0] only, and command data on data bits [7:0] only. Higher bits do not affect decoding.
- R13: op_valid is high for exactly the one clock after the clock edge that samples the completing write. Any other write in bypass mode, including F0, produces no pulse and keeps the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe marking a host write |
| wr_addr | input | AW | Address of the host write |
| wr_data | input | DW | Data of the host write |
| op_valid | output | 1 | One-cycle pulse for a decoded operation |
| op_code | output | 4 | Operation: 1 program, 2 sector erase, 3 chip erase, 4 autoselect, 5 bypass enter, 6 bypass exit, 7 suspend, 8 resume, 9 reset |
| op_addr | output | AW | Address of the completing write |
| op_data | output | DW | Data of the completing write |
| bypass_active | output | 1 | Bypass mode is active |
| autosel_active | output | 1 | Autoselect mode is active |

## Verification
A wrong internal sequence position does not show up when it happens. It shows up only at the next write that would complete or abort a sequence: either a pulse is missing, a pulse appears that should not, or the code is wrong. A wrong mode is visible at once on bypass_active or autosel_active, one clock after the write that caused it. For this reason the reference model is compared on every clock, under both directed sequences and a long biased random write stream, so that a divergence is reported in the cycle where it first reaches a port.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int UW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          op_valid,
  output logic [3:0]    op_code,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          bypass_active,
  output logic          autosel_active
);
  localparam logic [UW-1:0] ADR_HI = UW'(12'h555);
  localparam logic [UW-1:0] ADR_LO = UW'(12'h2AA);
  localparam logic [3:0] OP_NONE = 4'd0, OP_PROG = 4'd1, OP_SECT = 4'd2,
                         OP_CHIP = 4'd3, OP_ASEL = 4'd4, OP_BYEN = 4'd5,
                         OP_BYEX = 4'd6, OP_SUSP = 4'd7, OP_RESM = 4'd8,
                         OP_RST  = 4'd9;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM, S_ER1, S_ER2, S_ER3,
    S_BY_IDLE, S_BY_PGM, S_BY_EXIT, S_ASEL
  } st_t;

  st_t        st, nxt;
  logic       fire;
  logic [3:0] code;
  logic [7:0] d8;
  logic       at_hi, at_lo, seq_open;

  assign d8       = wr_data[7:0];
  assign at_hi    = wr_addr[UW-1:0] == ADR_HI;
  assign at_lo    = wr_addr[UW-1:0] == ADR_LO;
  assign seq_open = st inside {S_IDLE, S_UNL1, S_UNL2, S_ER1, S_ER2, S_ER3};

  assign bypass_active  = st inside {S_BY_IDLE, S_BY_PGM, S_BY_EXIT};
  assign autosel_active = st == S_ASEL;

  always_comb begin
    nxt  = st;
    fire = 1'b0;
    code = OP_NONE;
    if (seq_open && d8 == 8'hF0) begin
      fire = 1'b1; code = OP_RST; nxt = S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          if (d8 == 8'hB0) begin fire = 1'b1; code = OP_SUSP; end
          else if (d8 == 8'h30) begin fire = 1'b1; code = OP_RESM; end
          else if (d8 == 8'hAA && at_hi) nxt = S_UNL1;
        end
        S_UNL1: nxt = (d8 == 8'h55 && at_lo) ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          nxt = S_IDLE;
          if (at_hi) begin
            case (d8)
              8'hA0: nxt = S_PGM;
              8'h80: nxt = S_ER1;
              8'h90: begin nxt = S_ASEL; fire = 1'b1; code = OP_ASEL; end
              8'h20: begin nxt = S_BY_IDLE; fire = 1'b1; code = OP_BYEN; end
              default: nxt = S_IDLE;
            endcase
          end
        end
        S_PGM: begin fire = 1'b1; code = OP_PROG; nxt = S_IDLE; end
        S_ER1: nxt = (d8 == 8'hAA && at_hi) ? S_ER2 : S_IDLE;
        S_ER2: nxt = (d8 == 8'h55 && at_lo) ? S_ER3 : S_IDLE;
        S_ER3: begin
          nxt = S_IDLE;
          if (d8 == 8'h10 && at_hi) begin fire = 1'b1; code = OP_CHIP; end
          else if (d8 == 8'h30) begin fire = 1'b1; code = OP_SECT; end
        end
        S_BY_IDLE: begin
          if (d8 == 8'hA0) nxt = S_BY_PGM;
          else if (d8 == 8'h90) nxt = S_BY_EXIT;
          else if (d8 == 8'hB0) begin fire = 1'b1; code = OP_SUSP; end
          else if (d8 == 8'h30) begin fire = 1'b1; code = OP_RESM; end
        end
        S_BY_PGM: begin fire = 1'b1; code = OP_PROG; nxt = S_BY_IDLE; end
        S_BY_EXIT: begin
          nxt = S_BY_IDLE;
          if (d8 == 8'h00) begin fire = 1'b1; code = OP_BYEX; nxt = S_IDLE; end
        end
        S_ASEL: if (d8 == 8'hF0) begin fire = 1'b1; code = OP_RST; nxt = S_IDLE; end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_valid <= 1'b0;
      op_code  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= 1'b0;
      if (wr_en) begin
        st <= nxt;
        if (fire) begin
          op_valid <= 1'b1;
          op_code  <= code;
          op_addr  <= wr_addr;
          op_data  <= wr_data;
        end
      end
    end
  end

  a_r13_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_en));
  a_r13_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (!op_valid || $past(wr_en)));
  a_r6_bypass_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_active) |-> (op_valid && op_code == OP_BYEN));
  a_r8_bypass_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_active) |-> (op_valid && op_code == OP_BYEX));
  a_r5_autosel_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(autosel_active) |-> (op_valid && op_code == OP_ASEL));
  a_r5_autosel_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(autosel_active) |-> (op_valid && op_code == OP_RST));
  a_r5_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bypass_active && autosel_active));
  a_r4_chip_at_unlock_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CHIP) |-> (op_addr[UW-1:0] == ADR_HI && op_data[7:0] == 8'h10));
  a_r2_prog_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_code != OP_NONE && op_code <= OP_RST));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          op_valid;
  logic [3:0]    op_code;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          bypass_active;
  logic          autosel_active;

  flash_cmd_decoder #(.AW(AW), .DW(DW), .UW(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
    .bypass_active(bypass_active), .autosel_active(autosel_active)
  );

  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";
  bit    comparing = 1'b0;
  bit    finished = 1'b0;

  // reference model: mode 0 normal, 1 bypass, 2 autoselect
  int            mode = 0;
  logic [10:0]   qa[$];
  logic [7:0]    qd[$];
  logic          e_valid = 1'b0;
  int            e_code = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_data = '0;

  function automatic int eval_normal();
    int n = qd.size();
    logic [10:0] a = qa[n-1];
    logic [7:0]  d = qd[n-1];
    if (n == 4 && qd[2] == 8'hA0) return 1;
    if (d == 8'hF0) return 9;
    if (n == 1) begin
      if (d == 8'hB0) return 7;
      if (d == 8'h30) return 8;
      return (d == 8'hAA && a == 11'h555) ? 0 : -1;
    end
    if (n == 2 || n == 5) return (d == 8'h55 && a == 11'h2AA) ? 0 : -1;
    if (n == 3) begin
      if (a != 11'h555) return -1;
      if (d == 8'hA0 || d == 8'h80) return 0;
      if (d == 8'h90) return 4;
      if (d == 8'h20) return 5;
      return -1;
    end
    if (n == 4) return (d == 8'hAA && a == 11'h555) ? 0 : -1;
    if (d == 8'h10 && a == 11'h555) return 3;
    if (d == 8'h30) return 2;
    return -1;
  endfunction

  function automatic int eval_bypass();
    int n = qd.size();
    logic [7:0] d = qd[n-1];
    if (n == 1) begin
      if (d == 8'hA0 || d == 8'h90) return 0;
      if (d == 8'hB0) return 7;
      if (d == 8'h30) return 8;
      return -1;
    end
    if (qd[0] == 8'hA0) return 1;
    return (d == 8'h00) ? 6 : -1;
  endfunction

  always @(posedge clk) begin
    e_valid = 1'b0;
    if (!rst_n) begin
      mode = 0; qa.delete(); qd.delete(); e_code = 0;
    end else if (wr_en) begin
      int r;
      qa.push_back(wr_addr[10:0]);
      qd.push_back(wr_data[7:0]);
      if (mode == 0) r = eval_normal();
      else if (mode == 1) r = eval_bypass();
      else r = (wr_data[7:0] == 8'hF0) ? 9 : -1;
      if (r != 0) begin qa.delete(); qd.delete(); end
      if (r > 0) begin
        e_valid = 1'b1; e_code = r; e_addr = wr_addr; e_data = wr_data;
        if (r == 4) mode = 2;
        else if (r == 5) mode = 1;
        else if (r == 6 || (r == 9 && mode == 2)) mode = 0;
      end
    end
  end

  task automatic check(input string t, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && !finished) begin
      check(tag, "op_valid", op_valid, e_valid);
      check(tag, "bypass_active", bypass_active, mode == 1);
      check(tag, "autosel_active", autosel_active, mode == 2);
      if (e_valid) begin
        check(tag, "op_code", op_code, e_code);
        check(tag, "op_addr", op_addr, e_addr);
        check(tag, "op_data", op_data, e_data);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 22'h555, 16'h00AA);
    wr(hi | 22'h2AA, 16'h0055);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "op_valid in reset", op_valid, 0);
    check("R1", "op_code in reset", op_code, 0);
    check("R1", "bypass in reset", bypass_active, 0);
    check("R1", "autosel in reset", autosel_active, 0);
    rst_n = 1'b1;
    comparing = 1'b1;
    idle(2);

    tag = "R2"; unlock('0); wr(22'h555, 16'h00A0); wr(22'h3ABCDE, 16'hBEEF); idle(1);
    tag = "R10"; unlock('0); wr(22'h555, 16'h00A0); wr(22'h12345, 16'h00F0); idle(1);
    tag = "R3"; unlock('0); wr(22'h555, 16'h0080); unlock('0); wr(22'h1F0000, 16'h0030); idle(1);
    tag = "R4"; unlock('0); wr(22'h555, 16'h0080); unlock('0); wr(22'h555, 16'h0010); idle(1);
    tag = "R4"; unlock('0); wr(22'h555, 16'h0080); unlock('0); wr(22'h556, 16'h0010); idle(1);
    tag = "R12"; unlock(22'h3FF800); wr(22'h2AB555, 16'hFFA0); wr(22'h000777, 16'h1234); idle(1);
    tag = "R12"; wr(22'h554, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h555, 16'h00A0); wr(22'h40, 16'h0040); idle(1);
    tag = "R9"; unlock('0); wr(22'h555, 16'h0077); wr(22'h555, 16'h00A0); wr(22'h100, 16'h0001); idle(1);
    tag = "R9"; wr(22'h555, 16'h00AA); wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h555, 16'h00A0); idle(1);
    tag = "R10"; wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h00F0); idle(1);
    tag = "R11"; wr(22'h123, 16'h00B0); wr(22'h456, 16'h0030); idle(1);
    tag = "R5"; unlock('0); wr(22'h555, 16'h0090); wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055);
    wr(22'h555, 16'h0030); wr(22'h7, 16'h00B0); wr(22'h99, 16'hAAF0); idle(1);
    tag = "R6"; unlock('0); wr(22'h555, 16'h0020); idle(1);
    tag = "R7"; wr(22'h8, 16'h00A0); wr(22'h2000, 16'h5A5A); wr(22'h3, 16'h00A0); wr(22'h9, 16'h00F0); idle(1);
    tag = "R13"; wr(22'h555, 16'h00F0); wr(22'h555, 16'h00AA); wr(22'h1, 16'h0010); idle(1);
    tag = "R11"; wr(22'h0, 16'h00B0); wr(22'h0, 16'h0030); idle(1);
    tag = "R8"; wr(22'h0, 16'h0090); wr(22'h0, 16'h0001); wr(22'h0, 16'h0090); wr(22'h0, 16'h0000); idle(2);

    tag = "R9";
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] dsel [12] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'h20, 8'h10, 8'h30, 8'hB0, 8'hF0, 8'h00, 8'h5C};
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      int k = $urandom_range(0, 3);
      if (k == 0) a[10:0] = 11'h555; else if (k == 1) a[10:0] = 11'h2AA;
      d[7:0] = dsel[$urandom_range(0, 11)];
      @(negedge clk);
      wr_en = ($urandom_range(0, 3) != 0); wr_addr = a; wr_data = d;
    end
    @(negedge clk); wr_en = 1'b0;
    idle(2);
    finish_run();
  end
endmodule